// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing transaction engine of a serial memory that answers on a two-wire bus. It works from SCL and SDA levels that have already been synchronised to the system clock. It returns an open-drain enable for SDA, where a 1 pulls the line low. It spots START and STOP conditions and checks the device byte against a fixed type code and two strap inputs. After a write-mode device byte it collects a 16-bit word address, then either forwards data bytes to a page buffer or streams bytes read from an external address counter.

The address counter and the memory array sit outside the block. The block pulses `addr_ld_o` with a new counter value. It hands over each written byte with `wr_vld_o`. It pulses `wr_commit_o` to start a nonvolatile cycle, and it pulses `rd_next_o` each time it takes the byte on `rd_data_i`, so the counter then holds the last accessed address plus one. The owner of the page buffer discards pending bytes on `addr_ld_o`. While `busy_i` is high the block refuses every device byte, so a master can poll for the end of a write cycle.

A STOP straight after the word address only loads the counter. A read ends when the master leaves SDA high in the ninth clock.

Top module: `ee_slave_ctrl`

## Requirements
- R1: A device byte is accepted only when bits 7:4 are 1010, bits 3:2 equal `sel_i` and bit 1 is 0. Bit 0 selects read (1) or write (0). Acceptance is signalled by holding `sda_oe_o` high through the ninth clock.
- R2: After reset, and after a device byte that fails R1, `sda_oe_o` stays low until the next START, whatever bytes follow.
- R3: While `busy_i` is high, no device byte is acknowledged. Once `busy_i` falls, device bytes are acknowledged again.
- R4: After a write-mode device byte, two word-address bytes (high byte first) are each acknowledged. When the second one completes, `addr_ld_o` pulses for one cycle with the 16-bit address on `addr_o`.
- R5: Each later data byte is acknowledged and appears once on `wr_data_o` with a one-cycle `wr_vld_o` pulse. At most one of `addr_ld_o`, `wr_vld_o`, `wr_commit_o` and `rd_next_o` is high in any cycle.
- R6: A STOP that comes after at least one whole data byte and its acknowledge, and before any bit of the next byte, gives one `wr_commit_o` pulse. A STOP at any other point of a write gives no commit.
- R7: A STOP right after the word address loads the counter, gives no commit and leaves the block idle. A following current-address read returns the byte at the loaded address.
- R8: In a read, the byte on `rd_data_i` is sent MSB first, with a `rd_next_o` pulse for each byte taken. A current-address read starts from the counter, and a repeated START after the word address gives a random read.
- R9: An acknowledge from the master (SDA low) in the ninth clock of a read byte fetches and sends the next byte. A NACK (SDA high) releases SDA, which then stays released until the next START.
- R10: A START at any point abandons the current transfer, releases SDA and begins a fresh device-byte match.
- R11: `sda_oe_o` is asserted only in the cycle after SCL was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe_o | output | 1 | SDA pull-down enable (1 = drive low) |
| sel_i | input | 2 | Strap select bits compared with device byte bits 3:2 |
| busy_i | input | 1 | Nonvolatile cycle in progress |
| addr_ld_o | output | 1 | Load address counter from `addr_o` |
| addr_o | output | 16 | Received word address |
| wr_vld_o | output | 1 | Data byte valid for the page buffer |
| wr_data_o | output | 8 | Received data byte |
| wr_commit_o | output | 1 | Start the nonvolatile write cycle |
| rd_next_o | output | 1 | Byte taken from `rd_data_i`; advance the counter |
| rd_data_i | input | 8 | Byte at the current counter address |

## Verification
Some properties are checked on every cycle. SDA is only pulled low after SCL was low. The block stays silent while idle. A busy device byte always gets a NACK. A START always returns the engine to device matching with SDA released. A commit follows only a STOP, and the counter and buffer strobes never overlap. Other behaviour only shows over a whole transaction, so the scenarios cover it: the byte values and their order on the bus, the polling retry loop, and set-address followed by a current read. They also cover counter continuity across separate reads, and the check that an aborted write leaves the array contents unchanged.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DEV   = 3'd1,
    ST_ADDR  = 3'd2,
    ST_WDATA = 3'd3,
    ST_RDATA = 3'd4
  } ee_state_e;
endpackage

// File: rtl/ee_bus_cond.sv
module ee_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ee_bit_engine.sv
module ee_bit_engine #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_i,
  input  logic          rx_en_i,
  input  logic          load_en_i,
  input  logic [DW-1:0] load_data_i,
  output logic [CW-1:0] bit_cnt_o,
  output logic [DW-1:0] byte_o,
  output logic          tick_o,
  output logic          mack_o
);
  localparam logic [CW-1:0] ACK_SLOT = CW'(DW);

  logic          seen_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;
  logic          mack_q;

  // only a fall that closes a clock seen high counts
  assign tick_o    = scl_fall_i & seen_q;
  assign bit_cnt_o = cnt_q;
  assign byte_o    = sh_q;
  assign mack_o    = mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      mack_q <= 1'b0;
    end else if (restart_i) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (scl_rise_i) begin
        seen_q <= 1'b1;
        if (rx_en_i && cnt_q < ACK_SLOT) sh_q <= {sh_q[DW-2:0], sda_i};
        if (!rx_en_i && cnt_q == ACK_SLOT) mack_q <= ~sda_i;
      end
      if (tick_o) begin
        seen_q <= 1'b0;
        if (cnt_q == ACK_SLOT) begin
          cnt_q <= '0;
          if (load_en_i) sh_q <= load_data_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (!rx_en_i) sh_q <= {sh_q[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/ee_txn_fsm.sv
module ee_txn_fsm
  import ee_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int SEL_W = 2,
  parameter logic [DW-SEL_W-3:0] DEV_CODE = 4'b1010,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [CW-1:0]    bit_cnt_i,
  input  logic [DW-1:0]    byte_i,
  input  logic             mack_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             busy_i,
  input  logic             rd_msb_i,
  output ee_state_e        state_o,
  output logic             rx_en_o,
  output logic             load_en_o,
  output logic             sda_oe_o,
  output logic             addr_ld_o,
  output logic [AW-1:0]    addr_o,
  output logic             wr_vld_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             wr_commit_o,
  output logic             rd_next_o
);
  localparam int CODE_W = DW - SEL_W - 2;
  localparam int AB = AW / DW;
  localparam int IW = (AB > 1) ? $clog2(AB) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(AB - 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
  localparam logic [CW-1:0] ACK_SLOT = CW'(DW);

  ee_state_e     state_q;
  logic          rw_q, have_data_q, oe_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic          ld_q, wv_q, cm_q, rn_q;

  logic byte_done, ack_end, dev_match;
  assign byte_done = tick_i && (bit_cnt_i == LAST_BIT);
  assign ack_end   = tick_i && (bit_cnt_i == ACK_SLOT);
  assign dev_match = (byte_i[DW-1 -: CODE_W] == DEV_CODE) &&
                     (byte_i[2 +: SEL_W] == sel_i) && !byte_i[1];

  assign rx_en_o   = (state_q == ST_DEV) || (state_q == ST_ADDR) || (state_q == ST_WDATA);
  assign load_en_o = ((state_q == ST_DEV) && rw_q) || ((state_q == ST_RDATA) && mack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rw_q        <= 1'b0;
      have_data_q <= 1'b0;
      oe_q        <= 1'b0;
      idx_q       <= '0;
      addr_q      <= '0;
      wdat_q      <= '0;
      ld_q        <= 1'b0;
      wv_q        <= 1'b0;
      cm_q        <= 1'b0;
      rn_q        <= 1'b0;
    end else begin
      ld_q <= 1'b0;
      wv_q <= 1'b0;
      cm_q <= 1'b0;
      rn_q <= 1'b0;
      if (start_i) begin
        state_q     <= ST_DEV;
        oe_q        <= 1'b0;
        have_data_q <= 1'b0;
        idx_q       <= '0;
      end else if (stop_i) begin
        // commit only on a byte boundary after a whole acknowledged byte
        if (state_q == ST_WDATA && have_data_q && bit_cnt_i == '0) cm_q <= 1'b1;
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_DEV: begin
            if (byte_done) begin
              if (dev_match && !busy_i) begin
                rw_q <= byte_i[0];
                oe_q <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (ack_end) begin
              if (rw_q) begin
                state_q <= ST_RDATA;
                oe_q    <= ~rd_msb_i;
                rn_q    <= 1'b1;
              end else begin
                state_q <= ST_ADDR;
                idx_q   <= '0;
                oe_q    <= 1'b0;
              end
            end
          end
          ST_ADDR: begin
            if (byte_done) begin
              oe_q   <= 1'b1;
              addr_q <= {addr_q[AW-DW-1:0], byte_i};
              if (idx_q == LAST_IDX) ld_q <= 1'b1;
            end else if (ack_end) begin
              oe_q <= 1'b0;
              if (idx_q == LAST_IDX) state_q <= ST_WDATA;
              else idx_q <= idx_q + 1'b1;
            end
          end
          ST_WDATA: begin
            if (byte_done) begin
              oe_q   <= 1'b1;
              wv_q   <= 1'b1;
              wdat_q <= byte_i;
            end else if (ack_end) begin
              oe_q        <= 1'b0;
              have_data_q <= 1'b1;
            end
          end
          ST_RDATA: begin
            if (byte_done) begin
              oe_q <= 1'b0;
            end else if (ack_end) begin
              if (mack_i) begin
                oe_q <= ~rd_msb_i;
                rn_q <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
              end
            end else if (tick_i) begin
              oe_q <= ~byte_i[DW-2];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o     = state_q;
  assign sda_oe_o    = oe_q;
  assign addr_ld_o   = ld_q;
  assign addr_o      = addr_q;
  assign wr_vld_o    = wv_q;
  assign wr_data_o   = wdat_q;
  assign wr_commit_o = cm_q;
  assign rd_next_o   = rn_q;
endmodule

// File: rtl/ee_slave_ctrl.sv
module ee_slave_ctrl
  import ee_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int SEL_W = 2,
  parameter logic [DW-SEL_W-3:0] DEV_CODE = 4'b1010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             busy_i,
  output logic             addr_ld_o,
  output logic [AW-1:0]    addr_o,
  output logic             wr_vld_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             wr_commit_o,
  output logic             rd_next_o,
  input  logic [DW-1:0]    rd_data_i
);
  localparam int CW = $clog2(DW + 1);

  logic          rise_w, fall_w, start_w, stop_w;
  logic          tick_w, mack_w, rx_en_w, load_en_w;
  logic [CW-1:0] bit_cnt_w;
  logic [DW-1:0] byte_w;
  ee_state_e     state_w;

  ee_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (rise_w),
    .scl_fall_o (fall_w),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  ee_bit_engine #(.DW(DW)) u_bits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (start_w | stop_w),
    .scl_rise_i  (rise_w),
    .scl_fall_i  (fall_w),
    .sda_i       (sda_i),
    .rx_en_i     (rx_en_w),
    .load_en_i   (load_en_w),
    .load_data_i (rd_data_i),
    .bit_cnt_o   (bit_cnt_w),
    .byte_o      (byte_w),
    .tick_o      (tick_w),
    .mack_o      (mack_w)
  );

  ee_txn_fsm #(.DW(DW), .AW(AW), .SEL_W(SEL_W), .DEV_CODE(DEV_CODE)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .tick_i      (tick_w),
    .bit_cnt_i   (bit_cnt_w),
    .byte_i      (byte_w),
    .mack_i      (mack_w),
    .sel_i       (sel_i),
    .busy_i      (busy_i),
    .rd_msb_i    (rd_data_i[DW-1]),
    .state_o     (state_w),
    .rx_en_o     (rx_en_w),
    .load_en_o   (load_en_w),
    .sda_oe_o    (sda_oe_o),
    .addr_ld_o   (addr_ld_o),
    .addr_o      (addr_o),
    .wr_vld_o    (wr_vld_o),
    .wr_data_o   (wr_data_o),
    .wr_commit_o (wr_commit_o),
    .rd_next_o   (rd_next_o)
  );
endmodule

// File: rtl/ee_slave_ctrl_chk.sv
module ee_slave_ctrl_chk
  import ee_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = $clog2(DW + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic          busy_i,
  input logic          addr_ld_o,
  input logic          wr_vld_o,
  input logic          wr_commit_o,
  input logic          rd_next_o,
  input ee_state_e     state_i,
  input logic          tick_i,
  input logic [CW-1:0] bit_cnt_i,
  input logic          start_i,
  input logic          stop_i
);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  AST_DRIVE_AFTER_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_i)); // R11

  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> !sda_oe_o); // R2

  AST_BUSY_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DEV && tick_i && bit_cnt_i == LAST_BIT && busy_i)
      |=> (state_i == ST_IDLE && !sda_oe_o)); // R3

  AST_COMMIT_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> $past(stop_i)); // R6

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({addr_ld_o, wr_vld_o, wr_commit_o, rd_next_o})); // R5

  AST_START_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_i == ST_DEV && !sda_oe_o)); // R10
endmodule

bind ee_slave_ctrl ee_slave_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_oe_o    (sda_oe_o),
  .busy_i      (busy_i),
  .addr_ld_o   (addr_ld_o),
  .wr_vld_o    (wr_vld_o),
  .wr_commit_o (wr_commit_o),
  .rd_next_o   (rd_next_o),
  .state_i     (state_w),
  .tick_i      (tick_w),
  .bit_cnt_i   (bit_cnt_w),
  .start_i     (start_w),
  .stop_i      (stop_w)
);

// File: tb/tb_ee_slave_ctrl.sv
module tb_ee_slave_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b01;
  logic busy;
  logic sda_oe, addr_ld, wr_vld, wr_commit, rd_next;
  logic [15:0] addr;
  logic [7:0] wr_data, rd_data;
  wire sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ee_slave_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .sel_i(strap), .busy_i(busy), .addr_ld_o(addr_ld), .addr_o(addr),
    .wr_vld_o(wr_vld), .wr_data_o(wr_data), .wr_commit_o(wr_commit),
    .rd_next_o(rd_next), .rd_data_i(rd_data)
  );

  // environment: counter, page buffer, array, busy timer
  logic [7:0] mem [256];
  logic [15:0] cnt;
  logic [15:0] pa[$];
  logic [7:0] pd[$];
  int busy_cnt;
  assign rd_data = mem[cnt[7:0]];
  assign busy = (busy_cnt != 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      cnt <= '0;
      busy_cnt <= 0;
      pa.delete();
      pd.delete();
    end else begin
      if (addr_ld) begin
        cnt <= addr;
        pa.delete();
        pd.delete();
      end
      if (wr_vld) begin
        pa.push_back(cnt);
        pd.push_back(wr_data);
        cnt <= cnt + 1'b1;
      end
      if (rd_next) cnt <= cnt + 1'b1;
      if (wr_commit) begin
        for (int i = 0; i < pa.size(); i++) mem[pa[i][7:0]] <= pd[i];
        busy_cnt <= BUSY_CYC;
      end else if (busy_cnt > 0) begin
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard: kind 0 = counter load, 1 = data byte, 2 = commit
  typedef struct { int kind; int val; string req; } ev_t;
  ev_t exp_q[$];

  task automatic expect_ev(input int kind, input int val, input string req);
    ev_t e;
    e.kind = kind; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int kind, input int val);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R5", "unexpected strobe kind", kind, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == kind && e.val == val, e.req, "strobe kind/value",
          kind * 65536 + val, e.kind * 65536 + e.val);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (addr_ld)   observe(0, int'(addr));
      if (wr_vld)    observe(1, int'(wr_data));
      if (wr_commit) observe(2, 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(2); scl_m = 1'b1; tick(2); sda_m = 1'b0; tick(2); scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(2); scl_m = 1'b1; tick(2); sda_m = 1'b1; tick(2);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(2); scl_m = 1'b1; tick(4); scl_m = 1'b0; tick(2);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(2); scl_m = 1'b1; tick(2); b = sda_line; tick(2); scl_m = 1'b0; tick(2);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      d[i] = x;
    end
    put_bit(~ack);
  endtask

  localparam logic [7:0] DEV_W = {4'b1010, 2'b01, 1'b0, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, 2'b01, 1'b0, 1'b1};

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int tries;

    tick(5);
    chk(sda_oe == 1'b0, "R2", "reset sda_oe", sda_oe, 0);
    chk({addr_ld, wr_vld, wr_commit, rd_next} == 4'b0, "R5", "reset strobes",
        {addr_ld, wr_vld, wr_commit, rd_next}, 0);
    rst_n = 1'b1;
    tick(5);

    // R4 R5 R6: write three bytes at 0x0010
    expect_ev(0, 16'h0010, "R4");
    expect_ev(1, 8'hA5, "R5");
    expect_ev(1, 8'h3C, "R5");
    expect_ev(1, 8'h00, "R5");
    expect_ev(2, 0, "R6");
    bus_start;
    put_byte(DEV_W, ack); chk(ack, "R1", "write device byte ack", ack, 1);
    put_byte(8'h00, ack); chk(ack, "R4", "address high ack", ack, 1);
    put_byte(8'h10, ack); chk(ack, "R4", "address low ack", ack, 1);
    put_byte(8'hA5, ack); chk(ack, "R5", "data0 ack", ack, 1);
    put_byte(8'h3C, ack); chk(ack, "R5", "data1 ack", ack, 1);
    put_byte(8'h00, ack); chk(ack, "R5", "data2 ack", ack, 1);
    bus_stop;
    tick(4);

    // R3: acknowledge polling
    bus_start;
    put_byte(DEV_W, ack);
    chk(!ack, "R3", "device byte while busy", ack, 0);
    bus_stop;
    tries = 0;
    ack = 1'b0;
    while (!ack && tries < 20) begin
      tick(20);
      bus_start;
      put_byte(DEV_W, ack);
      bus_stop;
      tries++;
    end
    chk(ack, "R3", "ack once cycle ends", ack, 1);

    // R8 R9: random read of the written bytes
    expect_ev(0, 16'h0010, "R8");
    bus_start;
    put_byte(DEV_W, ack);
    put_byte(8'h00, ack);
    put_byte(8'h10, ack);
    bus_start;
    put_byte(DEV_R, ack); chk(ack, "R8", "read device byte ack", ack, 1);
    get_byte(d, 1'b1); chk(d == 8'hA5, "R8", "random read byte0", d, 8'hA5);
    get_byte(d, 1'b1); chk(d == 8'h3C, "R9", "sequential byte1", d, 8'h3C);
    get_byte(d, 1'b0); chk(d == 8'h00, "R9", "sequential byte2", d, 8'h00);
    tick(2);
    chk(sda_oe == 1'b0, "R9", "released after nack", sda_oe, 0);
    bus_stop;

    // R8: current-address read continues at 0x13
    bus_start;
    put_byte(DEV_R, ack);
    get_byte(d, 1'b0);
    chk(d == init_val(8'h13), "R8", "current address read", d, init_val(8'h13));
    bus_stop;

    // R7: set current address
    expect_ev(0, 16'h0040, "R7");
    bus_start;
    put_byte(DEV_W, ack);
    put_byte(8'h00, ack);
    put_byte(8'h40, ack);
    bus_stop;
    tick(4);
    chk(busy == 1'b0, "R7", "no write cycle after set address", busy, 0);
    bus_start;
    put_byte(DEV_R, ack);
    get_byte(d, 1'b0);
    chk(d == init_val(8'h40), "R7", "read from set address", d, init_val(8'h40));
    bus_stop;

    // R1 R2: mismatching device bytes
    bus_start;
    put_byte({4'b1011, 2'b01, 2'b00}, ack); chk(!ack, "R2", "wrong type code", ack, 0);
    put_byte(8'h00, ack); chk(!ack, "R2", "silent after mismatch", ack, 0);
    bus_start;
    put_byte({4'b1010, 2'b10, 2'b00}, ack); chk(!ack, "R1", "wrong strap bits", ack, 0);
    bus_start;
    put_byte({4'b1010, 2'b01, 2'b10}, ack); chk(!ack, "R1", "bit1 set", ack, 0);
    bus_stop;

    // R6: stop inside the second data byte aborts the write
    expect_ev(0, 16'h0020, "R6");
    expect_ev(1, 8'h77, "R6");
    bus_start;
    put_byte(DEV_W, ack);
    put_byte(8'h00, ack);
    put_byte(8'h20, ack);
    put_byte(8'h77, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop;
    tick(4);
    chk(busy == 1'b0, "R6", "no write cycle after mid-byte stop", busy, 0);
    expect_ev(0, 16'h0020, "R6");
    bus_start;
    put_byte(DEV_W, ack);
    put_byte(8'h00, ack);
    put_byte(8'h20, ack);
    bus_start;
    put_byte(DEV_R, ack);
    get_byte(d, 1'b0);
    chk(d == init_val(8'h20), "R6", "array unchanged after abort", d, init_val(8'h20));
    bus_stop;

    // R10: START inside an address byte restarts matching
    bus_start;
    put_byte(DEV_W, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_start;
    put_byte(DEV_R, ack); chk(ack, "R10", "ack after restart", ack, 1);
    get_byte(d, 1'b0);
    chk(d == init_val(8'h21), "R10", "read after restart", d, init_val(8'h21));
    bus_stop;

    tick(20);
    chk(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule